// File: doc/BRIEF.md
# Strip to Angle Coordinate Converter

This block turns a chamber-local cathode half-strip number into an azimuthal angle measured across the whole sector. The half-strip is scaled by a factor that belongs to the chamber type. A fixed starting angle for the chamber is then added. A small table indexed by the cathode pattern code supplies a fine correction. The result is a 12-bit angle whose two least significant bits are a quarter of a half-strip. All of this is done in a short pipeline of logic, with no large external lookup memory.

The chamber type and the starting angle are slow configuration inputs. The block copies them into internal registers only while it is idle, so a host may rewrite them at any time without disturbing conversions already under way. One conversion can be accepted on every clock cycle, and each result appears two cycles later together with a valid flag.

Top module: `strip_angle_conv`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly two clock cycles. A run of back-to-back inputs yields a run of back-to-back results in the same order.
- R2: Chamber type encoding, with the factor written in eighths: type 0 has factor 8/8, type 1 has 16/8, type 2 has 12/8 and type 3 has 6/8. The scaled angle is floor(half-strip × factor) as a 10-bit value. Types 1 and 3 use only the low 7 half-strip bits and ignore bit 7. Types 0 and 2 use all 8 bits.
- R3: The base angle is the scaled angle plus the latched 10-bit starting angle. The output is base × 4 + correction. For type 0 this reduces to adding a fixed value to the half-strip.
- R4: The correction depends on the 4-bit pattern code, in units of one output LSB. Code 2 gives −2. Odd codes 3, 5, 7 and 9 give +1. Even codes 4, 6 and 8 give −1. Codes 0, 1 and 10 to 15 give 0.
- R5: A result above 4095 is replaced by 4095 and does not wrap.
- R6: A result below 0 is replaced by 0.
- R7: The type and starting-angle inputs are copied into the internal registers on a clock edge only when `in_valid` is low and no conversion sits in the first pipeline stage. Changes made at any other time have no effect on results.
- R8: Synchronous active-high reset clears `out_valid` and `out_angle` to 0, sets the latched type to 0 and sets the latched starting angle to 0.
- R9: `out_angle` keeps its last value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_type | input | 2 | Chamber type select (latched while idle) |
| cfg_init | input | 10 | Starting angle of the chamber (latched while idle) |
| in_valid | input | 1 | A half-strip and a pattern code are presented |
| in_hstrip | input | 8 | Half-strip number inside the chamber |
| in_pattern | input | 4 | Cathode pattern code |
| out_valid | output | 1 | `out_angle` carries a new result |
| out_angle | output | 12 | Corrected sector angle |

## Verification
The bench aims at the limits of the arithmetic. A sum that lands just below 4095 must pass unchanged, while one just above it must pin to 4095; a design that wraps would return a small angle instead. A base of zero combined with the −2 correction must give 0 and not a huge unsigned value. Inputs with bit 7 set on the 7-bit chamber types expose a design that forgets to mask it, because the scaled angle would then jump by 128 times the factor. Rewriting the starting angle in the same cycle as a conversion, and while it is still in flight, catches a design that latches configuration too early. The next conversion after an idle cycle shows whether the new value was then picked up.

// File: rtl/strip_ang_pkg.sv
package strip_ang_pkg;

   localparam int TYPE_W    = 2;
   localparam int NUM_TYPES = 1 << TYPE_W;
   localparam int FAC_W     = 5;
   localparam int FRAC_W    = 3;
   localparam int CODE_W    = 4;
   localparam int FINE_W    = 2;

   // Scale factor of each chamber type, in eighths of a half-strip.
   function automatic logic [FAC_W-1:0] type_factor(input logic [TYPE_W-1:0] t);
      logic [FAC_W-1:0] f;
      case (t)
         2'd0:    f = FAC_W'(8);
         2'd1:    f = FAC_W'(16);
         2'd2:    f = FAC_W'(12);
         default: f = FAC_W'(6);
      endcase
      return f;
   endfunction

   // Chamber types whose half-strip field is only seven bits wide.
   function automatic logic type_is_narrow(input logic [TYPE_W-1:0] t);
      return t[0];
   endfunction

   // Fine correction of a pattern code, two's complement.
   function automatic logic [FINE_W-1:0] code_fine(input logic [CODE_W-1:0] p);
      logic [FINE_W-1:0] c;
      if (p == CODE_W'(2))
         c = 2'b10;
      else if ((p >= CODE_W'(3)) && (p <= CODE_W'(9)))
         c = p[0] ? 2'b01 : 2'b11;
      else
         c = 2'b00;
      return c;
   endfunction

endpackage

// File: rtl/sa_scale.sv
module sa_scale
   import strip_ang_pkg::*;
#(
   parameter int HS_W  = 8,
   parameter int ANG_W = 10,
   parameter int IMPL  = 0
) (
   input  logic [HS_W-1:0]   hstrip,
   input  logic [TYPE_W-1:0] ctype,
   output logic [ANG_W-1:0]  scaled
);

   localparam int PROD_W = HS_W + FAC_W;

   logic [HS_W-1:0]   hs_eff;
   logic [FAC_W-1:0]  factor;
   logic [PROD_W-1:0] prod;

   if (PROD_W < FRAC_W + ANG_W) begin : g_bad_width
      $error("sa_scale: product narrower than the scaled field");
   end
   if (HS_W < 2) begin : g_bad_hs
      $error("sa_scale: half-strip width too small");
   end

   always_comb begin
      factor = type_factor(ctype);
      hs_eff = hstrip;
      if (type_is_narrow(ctype))
         hs_eff[HS_W-1] = 1'b0;
   end

   if (IMPL == 0) begin : g_mul
      always_comb prod = PROD_W'(hs_eff) * PROD_W'(factor);
   end else begin : g_shift_add
      always_comb begin
         prod = '0;
         for (int i = 0; i < FAC_W; i++) begin
            if (factor[i])
               prod = prod + (PROD_W'(hs_eff) << i);
         end
      end
   end

   assign scaled = ANG_W'(prod >> FRAC_W);

endmodule

// File: rtl/sa_fine_rom.sv
module sa_fine_rom
   import strip_ang_pkg::*;
#(
   parameter int PAT_W     = 4,
   parameter int CORR_W    = 2,
   parameter int USE_TABLE = 1
) (
   input  logic [PAT_W-1:0]  code,
   output logic [CORR_W-1:0] fine
);

   localparam int DEPTH = 1 << PAT_W;

   if (PAT_W != CODE_W) begin : g_bad_pat
      $error("sa_fine_rom: pattern width must equal the package code width");
   end
   if (CORR_W != FINE_W) begin : g_bad_corr
      $error("sa_fine_rom: correction width must equal the package fine width");
   end

   if (USE_TABLE != 0) begin : g_table
      logic [CORR_W-1:0] rom [DEPTH];
      for (genvar g = 0; g < DEPTH; g++) begin : g_cell
         assign rom[g] = code_fine(CODE_W'(g));
      end
      assign fine = rom[code];
   end else begin : g_func
      assign fine = code_fine(code);
   end

endmodule

// File: rtl/sa_sat_add.sv
module sa_sat_add #(
   parameter int SUM_W  = 11,
   parameter int CORR_W = 2,
   parameter int OUT_W  = 12,
   parameter int SUB_W  = 2
) (
   input  logic [SUM_W-1:0]  base,
   input  logic [CORR_W-1:0] fine,
   output logic [OUT_W-1:0]  angle
);

   localparam int EXT_W = SUM_W + SUB_W + 1;
   localparam logic signed [EXT_W-1:0] MAX_S = EXT_W'((1 << OUT_W) - 1);

   logic signed [EXT_W-1:0] wide;
   logic signed [EXT_W-1:0] fine_ext;
   logic signed [EXT_W-1:0] base_ext;

   if (EXT_W <= OUT_W) begin : g_bad_ext
      $error("sa_sat_add: extended sum must be wider than the output");
   end
   if (CORR_W > SUB_W + 1) begin : g_bad_fine
      $error("sa_sat_add: correction wider than the fine step allows");
   end

   always_comb begin
      base_ext = $signed({1'b0, base, {SUB_W{1'b0}}});
      fine_ext = $signed({{(EXT_W-CORR_W){fine[CORR_W-1]}}, fine});
      wide     = base_ext + fine_ext;
      if (wide < 0)
         angle = '0;
      else if (wide > MAX_S)
         angle = '1;
      else
         angle = wide[OUT_W-1:0];
   end

endmodule

// File: rtl/strip_angle_conv.sv
module strip_angle_conv
   import strip_ang_pkg::*;
#(
   parameter int HS_W       = 8,
   parameter int ANG_W      = 10,
   parameter int OUT_W      = 12,
   parameter int PAT_W      = 4,
   parameter int CORR_W     = 2,
   parameter int SCALE_IMPL = 0,
   parameter int FINE_TABLE = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [TYPE_W-1:0] cfg_type,
   input  logic [ANG_W-1:0]  cfg_init,
   input  logic              in_valid,
   input  logic [HS_W-1:0]   in_hstrip,
   input  logic [PAT_W-1:0]  in_pattern,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_angle
);

   localparam int SUM_W = ANG_W + 1;
   localparam int SUB_W = OUT_W - ANG_W;

   if (OUT_W <= ANG_W) begin : g_bad_out
      $error("strip_angle_conv: output must be wider than the coarse angle");
   end
   if (SCALE_IMPL < 0 || SCALE_IMPL > 1) begin : g_bad_impl
      $error("strip_angle_conv: SCALE_IMPL must be 0 or 1");
   end

   logic [TYPE_W-1:0] cfg_type_q;
   logic [ANG_W-1:0]  cfg_init_q;
   logic              s1_valid;
   logic [SUM_W-1:0]  s1_base;
   logic [CORR_W-1:0] s1_fine;
   logic [ANG_W-1:0]  scaled;
   logic [CORR_W-1:0] fine;
   logic [OUT_W-1:0]  angle_nxt;
   logic              idle;

   assign idle = !in_valid && !s1_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_type_q <= '0;
         cfg_init_q <= '0;
      end else if (idle) begin
         cfg_type_q <= cfg_type;
         cfg_init_q <= cfg_init;
      end
   end

   sa_scale #(
      .HS_W  (HS_W),
      .ANG_W (ANG_W),
      .IMPL  (SCALE_IMPL)
   ) scale_i (
      .hstrip (in_hstrip),
      .ctype  (cfg_type_q),
      .scaled (scaled)
   );

   sa_fine_rom #(
      .PAT_W     (PAT_W),
      .CORR_W    (CORR_W),
      .USE_TABLE (FINE_TABLE)
   ) fine_i (
      .code (in_pattern),
      .fine (fine)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_valid <= 1'b0;
         s1_base  <= '0;
         s1_fine  <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_base <= {1'b0, scaled} + {1'b0, cfg_init_q};
            s1_fine <= fine;
         end
      end
   end

   sa_sat_add #(
      .SUM_W  (SUM_W),
      .CORR_W (CORR_W),
      .OUT_W  (OUT_W),
      .SUB_W  (SUB_W)
   ) sat_i (
      .base  (s1_base),
      .fine  (s1_fine),
      .angle (angle_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_angle <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid)
            out_angle <= angle_nxt;
      end
   end

endmodule

// File: rtl/strip_angle_conv_chk.sv
module strip_angle_conv_chk #(
   parameter int TYPE_W = 2,
   parameter int ANG_W  = 10,
   parameter int OUT_W  = 12
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              s1_valid,
   input logic              out_valid,
   input logic [OUT_W-1:0]  out_angle,
   input logic [TYPE_W-1:0] cfg_type,
   input logic [ANG_W-1:0]  cfg_init,
   input logic [TYPE_W-1:0] cfg_type_q,
   input logic [ANG_W-1:0]  cfg_init_q
);

   logic [1:0] warm;

   always_ff @(posedge clk) begin
      if (rst)
         warm <= '0;
      else if (warm != 2'd3)
         warm <= warm + 2'd1;
   end

   // R1
   valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
      (warm >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

   // R9
   angle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ((warm >= 2'd2) && !$past(in_valid, 2)) |-> $stable(out_angle));

   // R7
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid || s1_valid) |=> ($stable(cfg_type_q) && $stable(cfg_init_q)));

   // R7
   cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
      (!in_valid && !s1_valid) |=>
         ((cfg_type_q == $past(cfg_type)) && (cfg_init_q == $past(cfg_init))));

   // R8
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && (out_angle == '0) && (cfg_init_q == '0) && (cfg_type_q == '0)));

endmodule

bind strip_angle_conv strip_angle_conv_chk #(
   .TYPE_W (strip_ang_pkg::TYPE_W),
   .ANG_W  (ANG_W),
   .OUT_W  (OUT_W)
) chk_i (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .s1_valid   (s1_valid),
   .out_valid  (out_valid),
   .out_angle  (out_angle),
   .cfg_type   (cfg_type),
   .cfg_init   (cfg_init),
   .cfg_type_q (cfg_type_q),
   .cfg_init_q (cfg_init_q)
);

// File: tb/strip_angle_conv_tb.sv
`timescale 1ns/1ps
module strip_angle_conv_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic [1:0]  cfg_type;
   logic [9:0]  cfg_init;
   logic        in_valid;
   logic [7:0]  in_hstrip;
   logic [3:0]  in_pattern;
   logic        out_valid;
   logic [11:0] out_angle;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   strip_angle_conv dut_i (
      .clk        (clk),
      .rst        (rst),
      .cfg_type   (cfg_type),
      .cfg_init   (cfg_init),
      .in_valid   (in_valid),
      .in_hstrip  (in_hstrip),
      .in_pattern (in_pattern),
      .out_valid  (out_valid),
      .out_angle  (out_angle)
   );

   // {type, start angle, half-strip, pattern code, expected angle}
   localparam int NVEC = 12;
   localparam logic [35:0] VEC [NVEC] = '{
      {2'd0, 10'd100,  8'd50,   4'd10, 12'd600},  // R3 offset-only type
      {2'd0, 10'd100,  8'd50,   4'd3,  12'd601},  // R4 +1
      {2'd0, 10'd100,  8'd50,   4'd4,  12'd599},  // R4 -1
      {2'd0, 10'd100,  8'd50,   4'd2,  12'd598},  // R4 -2
      {2'd1, 10'd200,  8'h85,   4'd10, 12'd840},  // R2 factor 2, bit 7 ignored
      {2'd2, 10'd0,    8'd255,  4'd0,  12'd1528}, // R2 factor 1.5
      {2'd3, 10'd1,    8'hFF,   4'd5,  12'd385},  // R2 factor 0.75, 7 bits
      {2'd2, 10'd1023, 8'd255,  4'd3,  12'd4095}, // R5 saturation
      {2'd0, 10'd0,    8'd0,    4'd2,  12'd0},    // R6 floor at zero
      {2'd0, 10'd1023, 8'd0,    4'd9,  12'd4093}, // R5 just below the limit
      {2'd0, 10'd1023, 8'd1,    4'd9,  12'd4095}, // R5 just above the limit
      {2'd3, 10'd7,    8'h80,   4'd12, 12'd28}    // R2 bit 7 ignored, R4 zero code
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_vec(input logic [35:0] v, input int idx);
      string tag;
      tag = $sformatf("vec%0d R1/R2/R3/R4/R5/R6", idx);
      @(negedge clk);
      cfg_type = v[35:34];
      cfg_init = v[33:24];
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      in_valid   = 1'b1;
      in_hstrip  = v[23:16];
      in_pattern = v[15:12];
      @(negedge clk);
      in_valid = 1'b0;
      chk({tag, " R1 not early"}, 32'(out_valid), 32'd0);
      @(negedge clk);
      chk({tag, " R1 valid"}, 32'(out_valid), 32'd1);
      chk({tag, " angle"}, 32'(out_angle), 32'(v[11:0]));
      @(negedge clk);
      chk({tag, " R1 one cycle"}, 32'(out_valid), 32'd0);
      chk({tag, " R9 hold"}, 32'(out_angle), 32'(v[11:0]));
   endtask

   initial begin
      rst        = 1'b1;
      cfg_type   = '0;
      cfg_init   = '0;
      in_valid   = 1'b0;
      in_hstrip  = '0;
      in_pattern = '0;
      repeat (3) @(negedge clk);
      chk("R8 reset valid", 32'(out_valid), 32'd0);
      chk("R8 reset angle", 32'(out_angle), 32'd0);
      rst = 1'b0;

      for (int i = 0; i < NVEC; i++) run_vec(VEC[i], i);

      // R7: start angle rewritten while a conversion is in flight
      @(negedge clk);
      cfg_type = 2'd0;
      cfg_init = 10'd100;
      repeat (2) @(negedge clk);
      in_valid   = 1'b1;
      in_hstrip  = 8'd10;
      in_pattern = 4'd10;
      cfg_init   = 10'd500;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk("R7 busy change ignored valid", 32'(out_valid), 32'd1);
      chk("R7 busy change ignored angle", 32'(out_angle), 32'd440);

      // R1 / R7: back-to-back stream after the new start angle is picked up
      @(negedge clk);
      in_valid   = 1'b1;
      in_hstrip  = 8'd1;
      @(negedge clk);
      in_hstrip  = 8'd2;
      cfg_init   = 10'd0;
      @(negedge clk);
      in_hstrip  = 8'd3;
      chk("R1 stream first valid", 32'(out_valid), 32'd1);
      chk("R7 stream first angle", 32'(out_angle), 32'd2004);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R1 stream second valid", 32'(out_valid), 32'd1);
      chk("R7 stream second angle", 32'(out_angle), 32'd2008);
      @(negedge clk);
      chk("R1 stream third valid", 32'(out_valid), 32'd1);
      chk("R7 stream third angle", 32'(out_angle), 32'd2012);
      @(negedge clk);
      chk("R1 stream end", 32'(out_valid), 32'd0);
      chk("R9 stream hold", 32'(out_angle), 32'd2012);

      // R8: reset after activity clears the latched start angle
      rst = 1'b1;
      cfg_init = 10'd300;
      @(negedge clk);
      chk("R8 reset again valid", 32'(out_valid), 32'd0);
      chk("R8 reset again angle", 32'(out_angle), 32'd0);
      in_valid   = 1'b1;
      in_hstrip  = 8'd4;
      in_pattern = 4'd10;
      rst        = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk("R8 start angle cleared", 32'(out_angle), 32'd16);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule